// File: doc/BRIEF.md
# Transmit Impedance Calibration Sequencer

This block runs one transmit-driver impedance calibration for a serial link and turns the two measured calibration codes into driver-segment enable settings. The pull-down measurement is the N code and the pull-up measurement is the P code. A one-cycle `start` pulse names the link. The block then drives the analog calibration engine through a small 16-bit register port with a one-cycle read latency. It prepares the two override registers, raises the request bit, and polls until the engine reports done. On success it reads both codes, checks that they are in range, and computes margin, pre-emphasis and total-enable values in fixed point.

The results come out as three packed N/P pairs, N in the upper half, with a one-cycle write strobe. A driver-enable register bank can take them directly from those ports. The links are grouped in pairs that share one calibration engine, so calibration runs once per pair. Once a pair has calibrated successfully, a later start for either link of that pair ends at once with success and touches no register.

The scaling constants M and K0 are parameters. The defaults, M = 128 and K0 = 0, leave the margin and pre-emphasis at zero. Other values exercise those paths.

Top module: `tximp_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `busy`, `done`, `fail` and `res_wr` are 0. No register access is made until a start arrives.
- R2: A calibration start reads address 0 and writes it back with only bit 15 kept. It then writes 0x0140 to address 1, reads address 2, and writes that value back with bit 15 (request) set. These steps run in this order.
- R3: After the request the block only reads address 2. It continues until bit 14 (done) is set. Exactly three register writes are made in one calibration.
- R4: If bit 13 (error) of address 2 is set when done is first seen, the block ends with `done` = 1 and `fail` = 1 and gives no `res_wr`.
- R5: The N code is the low 9 bits of address 3 and the P code is the low 9 bits of address 4. If either code is below 80 or above 320, the run ends with `fail` = 1 and gives no `res_wr`. The bounds 80 and 320 themselves are accepted.
- R6: Each value is computed per code as follows. margin = (128−M)·code/2. pre = ((128·code − 2·margin)·K0)/128. total = 128·code − 2·margin − (pre & 1023). Each value is rounded as (v >> 9) + bit 8 of v. With the defaults, N = 0xDA and P = 0xC7 give totals 0x37 and 0x32, and pre and margin are zero.
- R7: On success `res_wr` is high for exactly one cycle, in the same cycle as `done`, with `fail` = 0. In that cycle `res_total`, `res_pre` and `res_margin` hold {N, P} of their value.
- R8: Links 2g and 2g+1 share completion flag g. If the flag is set, a start gives `done` = 1 and `fail` = 0 in the next cycle with no register access and no `res_wr`.
- R9: A successful run sets its pair's flag. A failed run leaves the flag clear.
- R10: A start while `busy` is high is ignored and produces no extra `done`.
- R11: `done` is a one-cycle pulse, and a read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to calibrate a link |
| link_idx | input | LINK_W | Link number sampled with `start` |
| busy | output | 1 | Calibration run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Run failed; valid with `done` |
| phy_rd | output | 1 | Register read strobe; data returns next cycle |
| phy_wr | output | 1 | Register write strobe |
| phy_addr | output | 3 | Register address |
| phy_wdata | output | 16 | Register write data |
| phy_rdata | input | 16 | Register read data, one cycle after `phy_rd` |
| res_wr | output | 1 | Result write strobe |
| res_total | output | 2*OUT_W | Rounded total enable {N, P} |
| res_pre | output | 2*OUT_W | Rounded pre-emphasis select {N, P} |
| res_margin | output | 2*OUT_W | Rounded margin select {N, P} |

## Verification
The checker watches several properties on every cycle. Reads and writes are mutually exclusive, and no access happens while idle. `done` is a single-cycle pulse that falls while the block is not busy and follows a start or a run. The result strobe comes only with a successful `done`, and `fail` never appears without `done`. Other behaviour can only be shown by the bench scenarios. These cover the exact register sequence and written values, the polling behaviour, and the arithmetic for two parameter sets. They also cover range bounds on both codes, the engine error path, the pair flags that skip or allow later runs, and a start ignored while a run is busy.

// File: rtl/tximp_pkg.sv
package tximp_pkg;

  localparam int DATA_W = 16;
  localparam int REG_AW = 3;

  // Register map of the calibration engine port
  localparam logic [REG_AW-1:0] A_OVR1  = 3'd0;
  localparam logic [REG_AW-1:0] A_OVR2  = 3'd1;
  localparam logic [REG_AW-1:0] A_CTRL  = 3'd2;
  localparam logic [REG_AW-1:0] A_NCODE = 3'd3;
  localparam logic [REG_AW-1:0] A_PCODE = 3'd4;

  localparam int B_OVR_EN = 15;
  localparam int B_REQ    = 15;
  localparam int B_DONE   = 14;
  localparam int B_ERR    = 13;

  localparam logic [DATA_W-1:0] OVR2_VALUE = 16'h0050 << 2;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_OVR1,
    S_WR_OVR1,
    S_WR_OVR2,
    S_RD_CTRL,
    S_WR_CTRL,
    S_POLL_RD,
    S_POLL_CHK,
    S_RD_N,
    S_RD_P,
    S_CAP_P,
    S_CHECK,
    S_CALC
  } seq_state_t;

endpackage

// File: rtl/tximp_math.sv
module tximp_math #(
  parameter int CODE_W    = 9,
  parameter int CALC_W    = 32,
  parameter int SCALE_M   = 128,
  parameter int SCALE_K0  = 0,
  parameter int FRAC_BITS = 9,
  parameter int PRE_MASK  = 1023,
  parameter int OUT_W     = 8
) (
  input  logic [CODE_W-1:0] code,
  output logic [OUT_W-1:0]  margin_q,
  output logic [OUT_W-1:0]  pre_q,
  output logic [OUT_W-1:0]  total_q
);

  localparam logic [CALC_W-1:0] M_GAP  = CALC_W'(128 - SCALE_M);
  localparam logic [CALC_W-1:0] K0_V   = CALC_W'(SCALE_K0);
  localparam logic [CALC_W-1:0] PMASK  = CALC_W'(PRE_MASK);

  function automatic logic [OUT_W-1:0] round_fx(input logic [CALC_W-1:0] v);
    logic [CALC_W-1:0] s;
    s = (v >> FRAC_BITS) + CALC_W'(v[FRAC_BITS-1]);
    return s[OUT_W-1:0];
  endfunction

  logic [CALC_W-1:0] c_w, scaled, margin_w, net_w, pre_w, total_w;

  always_comb begin
    c_w      = CALC_W'(code);
    scaled   = c_w << 7;
    margin_w = (M_GAP * c_w) >> 1;
    net_w    = scaled - (margin_w << 1);
    pre_w    = (net_w * K0_V) >> 7;
    total_w  = net_w - (pre_w & PMASK);
  end

  assign margin_q = round_fx(margin_w);
  assign pre_q    = round_fx(pre_w);
  assign total_q  = round_fx(total_w);

endmodule

// File: rtl/tximp_done_mem.sv
module tximp_done_mem #(
  parameter int NUM_GROUPS = 2,
  parameter int GRP_W      = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GRP_W-1:0] rd_grp,
  output logic             rd_hit,
  input  logic             wr_en,
  input  logic [GRP_W-1:0] wr_grp
);

  logic [NUM_GROUPS-1:0] flags;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags[g] <= 1'b0;
      else if (wr_en && wr_grp == GRP_W'(g))
        flags[g] <= 1'b1;
    end
  end

  assign rd_hit = flags[rd_grp];

endmodule

// File: rtl/tximp_seq.sv
module tximp_seq
  import tximp_pkg::*;
#(
  parameter int CODE_W          = 9,
  parameter int CODE_MIN        = 80,
  parameter int CODE_MAX        = 320,
  parameter int LINK_W          = 2,
  parameter int GRP_W           = 1,
  parameter int LINKS_PER_GROUP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LINK_W-1:0] link_idx,
  output logic [GRP_W-1:0]  look_grp,
  input  logic              grp_hit,
  output logic              mem_wr,
  output logic [GRP_W-1:0]  mem_grp,
  output logic              phy_rd,
  output logic              phy_wr,
  output logic [REG_AW-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  input  logic [DATA_W-1:0] phy_rdata,
  output logic [CODE_W-1:0] code_n,
  output logic [CODE_W-1:0] code_p,
  output logic              calc_load,
  output logic              busy,
  output logic              done,
  output logic              fail
);

  localparam logic [CODE_W-1:0] LO = CODE_W'(CODE_MIN);
  localparam logic [CODE_W-1:0] HI = CODE_W'(CODE_MAX);

  seq_state_t       state;
  logic [GRP_W-1:0] cur_grp;
  logic             range_bad;

  assign look_grp  = GRP_W'(32'(link_idx) / LINKS_PER_GROUP);
  assign range_bad = (code_n < LO) || (code_n > HI) ||
                     (code_p < LO) || (code_p > HI);
  assign busy      = (state != S_IDLE);
  assign calc_load = (state == S_CALC);
  assign mem_wr    = (state == S_CALC);
  assign mem_grp   = cur_grp;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cur_grp <= '0;
      code_n  <= '0;
      code_p  <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            cur_grp <= look_grp;
            if (grp_hit) done  <= 1'b1;
            else         state <= S_RD_OVR1;
          end
        end
        S_RD_OVR1:  state <= S_WR_OVR1;
        S_WR_OVR1:  state <= S_WR_OVR2;
        S_WR_OVR2:  state <= S_RD_CTRL;
        S_RD_CTRL:  state <= S_WR_CTRL;
        S_WR_CTRL:  state <= S_POLL_RD;
        S_POLL_RD:  state <= S_POLL_CHK;
        S_POLL_CHK: begin
          if (!phy_rdata[B_DONE]) begin
            state <= S_POLL_RD;
          end else if (phy_rdata[B_ERR]) begin
            done  <= 1'b1;
            fail  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_RD_N;
          end
        end
        S_RD_N:     state <= S_RD_P;
        S_RD_P: begin
          code_n <= phy_rdata[CODE_W-1:0];
          state  <= S_CAP_P;
        end
        S_CAP_P: begin
          code_p <= phy_rdata[CODE_W-1:0];
          state  <= S_CHECK;
        end
        S_CHECK: begin
          if (range_bad) begin
            done  <= 1'b1;
            fail  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_CALC;
          end
        end
        S_CALC: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    phy_rd    = 1'b0;
    phy_wr    = 1'b0;
    phy_addr  = A_OVR1;
    phy_wdata = '0;
    unique case (state)
      S_RD_OVR1: begin
        phy_rd   = 1'b1;
        phy_addr = A_OVR1;
      end
      S_WR_OVR1: begin
        phy_wr    = 1'b1;
        phy_addr  = A_OVR1;
        phy_wdata = phy_rdata & (DATA_W'(1) << B_OVR_EN);
      end
      S_WR_OVR2: begin
        phy_wr    = 1'b1;
        phy_addr  = A_OVR2;
        phy_wdata = OVR2_VALUE;
      end
      S_RD_CTRL, S_POLL_RD: begin
        phy_rd   = 1'b1;
        phy_addr = A_CTRL;
      end
      S_WR_CTRL: begin
        phy_wr    = 1'b1;
        phy_addr  = A_CTRL;
        phy_wdata = phy_rdata | (DATA_W'(1) << B_REQ);
      end
      S_RD_N: begin
        phy_rd   = 1'b1;
        phy_addr = A_NCODE;
      end
      S_RD_P: begin
        phy_rd   = 1'b1;
        phy_addr = A_PCODE;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tximp_top.sv
module tximp_top
  import tximp_pkg::*;
#(
  parameter int NUM_LINKS       = 4,
  parameter int LINKS_PER_GROUP = 2,
  parameter int CODE_W          = 9,
  parameter int CODE_MIN        = 80,
  parameter int CODE_MAX        = 320,
  parameter int SCALE_M         = 128,
  parameter int SCALE_K0        = 0,
  parameter int FRAC_BITS       = 9,
  parameter int CALC_W          = 32,
  parameter int OUT_W           = 8,
  localparam int LINK_W     = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int NUM_GROUPS = NUM_LINKS / LINKS_PER_GROUP,
  localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [LINK_W-1:0]    link_idx,
  output logic                 busy,
  output logic                 done,
  output logic                 fail,
  output logic                 phy_rd,
  output logic                 phy_wr,
  output logic [REG_AW-1:0]    phy_addr,
  output logic [DATA_W-1:0]    phy_wdata,
  input  logic [DATA_W-1:0]    phy_rdata,
  output logic                 res_wr,
  output logic [2*OUT_W-1:0]   res_total,
  output logic [2*OUT_W-1:0]   res_pre,
  output logic [2*OUT_W-1:0]   res_margin
);

  logic [GRP_W-1:0]  look_grp, mem_grp;
  logic              grp_hit, mem_wr, calc_load;
  logic [CODE_W-1:0] codes [2];
  logic [OUT_W-1:0]  mg [2];
  logic [OUT_W-1:0]  pr [2];
  logic [OUT_W-1:0]  tt [2];

  tximp_seq #(
    .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX),
    .LINK_W(LINK_W), .GRP_W(GRP_W), .LINKS_PER_GROUP(LINKS_PER_GROUP)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .link_idx(link_idx),
    .look_grp(look_grp), .grp_hit(grp_hit),
    .mem_wr(mem_wr), .mem_grp(mem_grp),
    .phy_rd(phy_rd), .phy_wr(phy_wr), .phy_addr(phy_addr),
    .phy_wdata(phy_wdata), .phy_rdata(phy_rdata),
    .code_n(codes[0]), .code_p(codes[1]), .calc_load(calc_load),
    .busy(busy), .done(done), .fail(fail)
  );

  tximp_done_mem #(.NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W)) u_mem (
    .clk(clk), .rst(rst), .rd_grp(look_grp), .rd_hit(grp_hit),
    .wr_en(mem_wr), .wr_grp(mem_grp)
  );

  // channel 0 = N code, channel 1 = P code
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    tximp_math #(
      .CODE_W(CODE_W), .CALC_W(CALC_W), .SCALE_M(SCALE_M),
      .SCALE_K0(SCALE_K0), .FRAC_BITS(FRAC_BITS), .PRE_MASK(1023),
      .OUT_W(OUT_W)
    ) u_math (
      .code(codes[ch]), .margin_q(mg[ch]), .pre_q(pr[ch]), .total_q(tt[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_wr     <= 1'b0;
      res_total  <= '0;
      res_pre    <= '0;
      res_margin <= '0;
    end else begin
      res_wr <= calc_load;
      if (calc_load) begin
        res_total  <= {tt[0], tt[1]};
        res_pre    <= {pr[0], pr[1]};
        res_margin <= {mg[0], mg[1]};
      end
    end
  end

endmodule

// File: rtl/tximp_chk.sv
module tximp_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic fail,
  input logic phy_rd,
  input logic phy_wr,
  input logic res_wr
);

  a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !(phy_rd && phy_wr));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(phy_rd || phy_wr));

  a_r7_wr_with_done: assert property (@(posedge clk) disable iff (rst)
    res_wr |-> (done && !fail));

  a_r4_fail_with_done: assert property (@(posedge clk) disable iff (rst)
    fail |-> done);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r3_done_has_cause: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) || $past(start)));

endmodule

bind tximp_top tximp_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .fail(fail), .phy_rd(phy_rd), .phy_wr(phy_wr), .res_wr(res_wr)
);

// File: tb/test_tximp_top.sv
module tximp_phy_model (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic [15:0] cfg_ovr1,
  input  logic [15:0] cfg_n,
  input  logic [15:0] cfg_p,
  input  int          cfg_delay,
  input  logic        cfg_err,
  output int          n_rd,
  output int          n_wr,
  output logic [15:0] last_ovr1,
  output logic [15:0] last_ovr2,
  output logic [15:0] last_ctrl,
  output int          order_ok
);
  logic req, dn;
  int   cnt;
  int   wr_seq;

  always @(posedge clk) begin
    if (rst) begin
      rdata <= '0; req <= 0; dn <= 0; cnt <= 0; n_rd <= 0; n_wr <= 0;
      last_ovr1 <= '0; last_ovr2 <= '0; last_ctrl <= '0;
      wr_seq <= 0; order_ok <= 1;
    end else begin
      if (rd) begin
        n_rd <= n_rd + 1;
        case (addr)
          3'd0: rdata <= cfg_ovr1;
          3'd1: rdata <= last_ovr2;
          3'd2: rdata <= {req, dn, dn & cfg_err, 13'h0};
          3'd3: rdata <= cfg_n;
          3'd4: rdata <= cfg_p;
          default: rdata <= '0;
        endcase
      end
      if (wr) begin
        n_wr <= n_wr + 1;
        // expected write order within a run: addr 0, 1, 2
        if (32'(addr) != wr_seq % 3) order_ok <= 0;
        wr_seq <= wr_seq + 1;
        if (addr == 3'd0) last_ovr1 <= wdata;
        if (addr == 3'd1) last_ovr2 <= wdata;
        if (addr == 3'd2) last_ctrl <= wdata;
      end
      if (wr && addr == 3'd2 && wdata[15]) begin
        req <= 1; dn <= 0; cnt <= cfg_delay;
      end else if (cnt > 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) dn <= 1;
      end
    end
  end
endmodule

module test_tximp_top;
  localparam int OW = 8;
  localparam int ALT_M = 96;
  localparam int ALT_K0 = 16;

  logic clk = 0, rst = 1, start = 0;
  logic [1:0] link = 0;
  logic [15:0] cfg_ovr1 = 16'hFFFF, cfg_n = 0, cfg_p = 0;
  int cfg_delay = 3;
  logic cfg_err = 0;

  logic busy_a, done_a, fail_a, rd_a, wr_a, rw_a;
  logic [2:0] addr_a; logic [15:0] wd_a, rdat_a;
  logic [2*OW-1:0] tot_a, pre_a, mar_a;
  logic busy_b, done_b, fail_b, rd_b, wr_b, rw_b;
  logic [2:0] addr_b; logic [15:0] wd_b, rdat_b;
  logic [2*OW-1:0] tot_b, pre_b, mar_b;
  int nrd_a, nwr_a, nrd_b, nwr_b, ord_a, ord_b;
  logic [15:0] lo1_a, lo2_a, lc_a, lo1_b, lo2_b, lc_b;

  int n_checks = 0, n_fail = 0;
  int ev_done_a = 0, ev_wr_a = 0, ev_done_b = 0, ev_wr_b = 0;
  bit finished = 0;
  bit grp_flag [2];

  always #5 clk = ~clk;

  tximp_top i_tximp_top (
    .clk(clk), .rst(rst), .start(start), .link_idx(link),
    .busy(busy_a), .done(done_a), .fail(fail_a),
    .phy_rd(rd_a), .phy_wr(wr_a), .phy_addr(addr_a), .phy_wdata(wd_a),
    .phy_rdata(rdat_a), .res_wr(rw_a), .res_total(tot_a),
    .res_pre(pre_a), .res_margin(mar_a));

  tximp_top #(.SCALE_M(ALT_M), .SCALE_K0(ALT_K0)) i_tximp_top_alt (
    .clk(clk), .rst(rst), .start(start), .link_idx(link),
    .busy(busy_b), .done(done_b), .fail(fail_b),
    .phy_rd(rd_b), .phy_wr(wr_b), .phy_addr(addr_b), .phy_wdata(wd_b),
    .phy_rdata(rdat_b), .res_wr(rw_b), .res_total(tot_b),
    .res_pre(pre_b), .res_margin(mar_b));

  tximp_phy_model m_a (.clk(clk), .rst(rst), .rd(rd_a), .wr(wr_a),
    .addr(addr_a), .wdata(wd_a), .rdata(rdat_a), .cfg_ovr1(cfg_ovr1),
    .cfg_n(cfg_n), .cfg_p(cfg_p), .cfg_delay(cfg_delay), .cfg_err(cfg_err),
    .n_rd(nrd_a), .n_wr(nwr_a), .last_ovr1(lo1_a), .last_ovr2(lo2_a),
    .last_ctrl(lc_a), .order_ok(ord_a));

  tximp_phy_model m_b (.clk(clk), .rst(rst), .rd(rd_b), .wr(wr_b),
    .addr(addr_b), .wdata(wd_b), .rdata(rdat_b), .cfg_ovr1(cfg_ovr1),
    .cfg_n(cfg_n), .cfg_p(cfg_p), .cfg_delay(cfg_delay), .cfg_err(cfg_err),
    .n_rd(nrd_b), .n_wr(nwr_b), .last_ovr1(lo1_b), .last_ovr2(lo2_b),
    .last_ctrl(lc_b), .order_ok(ord_b));

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int rnd9(input int unsigned v);
    return int'(((v >> 9) + ((v >> 8) & 1)) & 32'hFF);
  endfunction

  function automatic void ref_calc(input int code, input int m, input int k0,
                                   output int mg, output int pr, output int tt);
    int unsigned c, marg, net, pre, tot;
    c    = code;
    marg = (128 - m) * c / 2;
    net  = 128 * c - 2 * marg;
    pre  = (net * k0) / 128;
    tot  = net - (pre & 1023);
    mg = rnd9(marg); pr = rnd9(pre); tt = rnd9(tot);
  endfunction

  // every-clock monitor of strobes against the bench's own rules
  always @(negedge clk) if (!rst) begin
    if (done_a) ev_done_a++;
    if (rw_a)   ev_wr_a++;
    if (done_b) ev_done_b++;
    if (rw_b)   ev_wr_b++;
    if (rw_a && !(done_a && !fail_a)) chk("R7 strobe a", 0, rw_a, 0);
    if (rw_b && !(done_b && !fail_b)) chk("R7 strobe b", 0, rw_b, 0);
    if (done_a !== done_b) chk("R11 lockstep", 0, done_a, done_b);
  end

  task automatic check_vals(input int n, input int p);
    int mn, pn, tn, mp, pp, tp;
    ref_calc(n, 128, 0, mn, pn, tn);
    ref_calc(p, 128, 0, mp, pp, tp);
    chk("R6 total default", tot_a == {tn[7:0], tp[7:0]}, tot_a, {tn[7:0], tp[7:0]});
    chk("R6 pre default", pre_a == {pn[7:0], pp[7:0]}, pre_a, {pn[7:0], pp[7:0]});
    chk("R6 margin default", mar_a == {mn[7:0], mp[7:0]}, mar_a, {mn[7:0], mp[7:0]});
    ref_calc(n, ALT_M, ALT_K0, mn, pn, tn);
    ref_calc(p, ALT_M, ALT_K0, mp, pp, tp);
    chk("R6 total alt", tot_b == {tn[7:0], tp[7:0]}, tot_b, {tn[7:0], tp[7:0]});
    chk("R6 pre alt", pre_b == {pn[7:0], pp[7:0]}, pre_b, {pn[7:0], pp[7:0]});
    chk("R6 margin alt", mar_b == {mn[7:0], mp[7:0]}, mar_b, {mn[7:0], mp[7:0]});
  endtask

  // Runs one calibration request on both instances
  task automatic run_cal(input int lk, input int n, input int p, input int dly,
                         input bit err, input logic [15:0] ovr1, input bit inject);
    int grp, wr0, rd0, d0, w0;
    bit exp_ok, got;
    grp = lk / 2;
    exp_ok = !err && n >= 80 && n <= 320 && p >= 80 && p <= 320;
    cfg_n = 16'hFE00 | 16'(n); cfg_p = 16'hFE00 | 16'(p);
    cfg_delay = dly; cfg_err = err; cfg_ovr1 = ovr1;
    wr0 = nwr_a; rd0 = nrd_a; d0 = ev_done_a; w0 = ev_wr_a;
    @(negedge clk); start = 1; link = 2'(lk);
    @(negedge clk); start = 0;
    if (grp_flag[grp]) begin
      chk("R8 short done", done_a && done_b, done_a, 1);
      chk("R8 short ok", !fail_a && !fail_b, fail_a, 0);
      chk("R8 short no wr", !rw_a && !rw_b, rw_a, 0);
      repeat (3) @(negedge clk);
      chk("R8 no access", nwr_a == wr0 && nrd_a == rd0, nwr_a + nrd_a, wr0 + rd0);
      return;
    end
    got = 0;
    for (int i = 0; i < 400; i++) begin
      if (done_a) begin got = 1; break; end
      if (inject && i == 3) begin start = 1; link = 0; end
      else start = 0;
      @(negedge clk);
    end
    start = 0;
    chk("R3 run ends", got, got, 1);
    chk(exp_ok ? "R7 success" : (err ? "R4 engine error" : "R5 range fail"),
        fail_a == !exp_ok && fail_b == !exp_ok, fail_a, !exp_ok);
    chk("R7 strobe matches", rw_a == exp_ok && rw_b == exp_ok, rw_a, exp_ok);
    chk("R3 three writes", nwr_a - wr0 == 3 && nwr_b == nwr_a, nwr_a - wr0, 3);
    chk("R2 write order", ord_a == 1 && ord_b == 1, ord_a, 1);
    chk("R2 override kept bit", lo1_a == (ovr1 & 16'h8000), lo1_a, ovr1 & 16'h8000);
    chk("R2 override2 value", lo2_a == 16'h0140, lo2_a, 16'h0140);
    chk("R2 request bit", lc_a[15] == 1'b1, lc_a, 16'h8000);
    if (exp_ok) begin
      check_vals(n, p);
      grp_flag[grp] = 1;
    end
    repeat (4) @(negedge clk);
    chk("R10 single done", ev_done_a - d0 == 1, ev_done_a - d0, 1);
    chk("R11 single strobe", ev_wr_a - w0 == int'(exp_ok), ev_wr_a - w0, exp_ok);
  endtask

  initial begin
    grp_flag[0] = 0; grp_flag[1] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", !busy_a && !done_a && !fail_a && !rw_a, {busy_a, done_a, fail_a, rw_a}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", !busy_a && !done_a && !rd_a && !wr_a && !busy_b, {busy_a, done_a, rd_a, wr_a}, 0);
    repeat (3) @(negedge clk);
    chk("R1 no access", nrd_a == 0 && nwr_a == 0, nrd_a + nwr_a, 0);

    run_cal(0, 'hDA, 'hC7, 3, 0, 16'hFFFF, 0);
    chk("R6 known totals", tot_a == 16'h3732 && pre_a == 0 && mar_a == 0, tot_a, 16'h3732);
    run_cal(1, 'hDA, 'hC7, 3, 0, 16'hFFFF, 0);     // R8 shared flag
    run_cal(2, 'hDA, 'hC7, 1, 1, 16'hFFFF, 0);     // R4 error
    run_cal(3, 79, 'hC7, 2, 0, 16'hFFFF, 0);       // R5 low N
    run_cal(2, 'hDA, 321, 2, 0, 16'hFFFF, 0);      // R5 high P, R9 no flag
    run_cal(2, 320, 80, 6, 0, 16'h7FFF, 1);        // R5 bounds, R10 inject
    run_cal(3, 100, 100, 2, 0, 16'hFFFF, 0);       // R9 flag set -> short
    run_cal(0, 150, 150, 2, 0, 16'hFFFF, 0);       // R8 again

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule